// File: doc/BRIEF.md
# PCI Function Configuration Header Register File

This block holds the type-0 configuration header of one PCI function. A host-side configuration agent reaches it through a simple synchronous port that carries a dword register number, four byte enables and write data. A read answers one cycle later with a data word and a valid pulse. The register number is wide enough to cover the 4096-byte extended space of a PCIe function. Any dword the header does not implement reads as zero and ignores writes.

The header provides a fixed identity pair, a command register whose enable bits drive output pins, and a read-only status word that flags a capability list. It also has six base address registers and a capability pointer leading to a short chain of read-only capability headers. Each base address register has a power-of-two size chosen by a parameter. The address bits below that size are tied to zero, so writing all ones and reading back gives a size mask. A base address register with size parameter 0 is absent and reads as zero.

The port has no state machine. Its two cycle-level conditions are an idle cycle and a cycle with a request. A read request is followed in the next cycle by a response cycle with `cfg_rvalid` high. A write request changes the register at that clock edge, so a read issued in the next cycle already sees the new value.

Top module: `cfg_endpoint_regs`

## Requirements
- R1: After reset the command register is zero and all three enable outputs are low. With the default parameters, base registers 0 to 3 read back only their fixed low bits: 0x00000000, 0x00000008, 0x00000001 and 0x00000000.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor code in bits 15:0 and the device code in bits 31:16. Writes to dword 0 do not change it.
- R3: In dword 1, bit 0 is I/O space enable, bit 1 is memory space enable and bit 2 is bus master enable. These three bits are writable through byte lane 0 and appear on `io_space_en`, `mem_space_en` and `bus_master_en`. All other command bits (15:3) read as zero.
- R4: Bits 31:16 of dword 1 form the status word. Only bit 20 (capability list present) reads as one, and writes do not change the status word.
- R5: Base registers sit at dwords 4 to 9. With the default sizes, writing 0xFFFFFFFF gives these readbacks: register 0 (16-byte memory) 0xFFFFFFF0; register 1 (4 KiB prefetchable memory, bit 3 set) 0xFFFFF008; register 2 (32-byte I/O, bit 0 set) 0xFFFFFFE1; register 3 (256-byte memory) 0xFFFFFF00.
- R6: After 0x12345678 is written, base registers 0 to 3 read 0x12345670, 0x12345008, 0x12345661 and 0x12345600. Each value is the written base with the bits below the region size cleared, combined with the fixed low bits.
- R7: With the default parameters, base registers 4 and 5 are absent and read 0x00000000 even after an all-ones write.
- R8: Byte enable bit k qualifies data bits 8k+7:8k of a write. A byte whose enable is low keeps its previous value.
- R9: Dword 13 reads 0x00000040, the offset of the first capability. The capability at 0x40 reads 0x00005001 (ID 0x01, next pointer 0x50). The capability at 0x50 reads 0x00000005 (ID 0x05, next pointer 0x00, which ends the chain).
- R10: Dwords the header does not implement read as zero and ignore writes. Examples are dword 2, the dwords inside a capability after its header, the rest of the 256-byte legacy space, and the extended space up to dword 0x3FF.
- R11: `cfg_rvalid` is high in exactly the cycle after a read request and low otherwise. A write request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Access request this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw | input | 10 | Dword register number (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cfg_rdata | output | 32 | Read data |
| io_space_en | output | 1 | Command bit 0 |
| mem_space_en | output | 1 | Command bit 1 |
| bus_master_en | output | 1 | Command bit 2 |

## Verification
Each base register is driven with three kinds of data: the all-ones probe, a base address with ones in its low bits, and partial writes under byte enables. Together these separate the size mask from the fixed type bits and from byte lane steering. Writes aimed at the identity, status, absent-register and unimplemented dwords are each followed by a read-back. This shows which storage a stray write could have reached. Walking the chain from dword 13 checks that every next pointer lands on a real header and that the chain ends in zero. Single-byte command writes on lane 0 and on the other lanes separate the enable bits from the bits tied to zero.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int NUM_BARS     = 6;
    localparam int SPACE_BYTES  = 4096;
    localparam int DW_BITS      = $clog2(SPACE_BYTES / 4);
    localparam int ID_DW        = 0;
    localparam int CMD_DW       = 1;
    localparam int BAR_FIRST_DW = 4;
    localparam int CAPPTR_DW    = 13;

    typedef struct packed {
        logic bm_en;
        logic mem_en;
        logic io_en;
    } cmd_t;

    function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
    import cfgsp_pkg::*;
#(
    parameter logic [6*NUM_BARS-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd8, 6'd5, 6'd12, 6'd4},
    parameter logic [NUM_BARS-1:0]   BAR_IO   = 6'b000100,
    parameter logic [NUM_BARS-1:0]   BAR_PREF = 6'b000010
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BARS-1:0]      wr_sel,
    input  logic [3:0]               be,
    input  logic [31:0]              wdata,
    output logic [32*NUM_BARS-1:0]   bar_rd
);

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam int          LOG2 = int'(BAR_LOG2[6*i +: 6]);
        localparam logic [31:0] LOWB = BAR_IO[i] ? 32'h1 : {28'h0, BAR_PREF[i], 3'b000};

        if (LOG2 == 0) begin : g_absent
            assign bar_rd[32*i +: 32] = 32'h0;
        end else begin : g_present
            localparam logic [31:0] AMASK = ~((32'h1 << LOG2) - 32'h1);
            logic [31:0] base_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q <= '0;
                end else if (wr_sel[i]) begin
                    base_q <= merge_be(base_q, wdata, be) & AMASK;
                end
            end

            assign bar_rd[32*i +: 32] = base_q | LOWB;
        end
    end

endmodule

// File: rtl/cfg_cap_chain.sv
module cfg_cap_chain
    import cfgsp_pkg::*;
#(
    parameter int                  CAP_COUNT  = 2,
    parameter int                  CAP_BASE   = 'h40,
    parameter int                  CAP_STRIDE = 16,
    parameter logic [8*CAP_COUNT-1:0] CAP_IDS = {8'h05, 8'h01}
) (
    input  logic [DW_BITS-1:0] dw,
    output logic               hit,
    output logic [31:0]        data
);

    logic [CAP_COUNT-1:0]    hit_v;
    logic [32*CAP_COUNT-1:0] hdr_v;

    for (genvar i = 0; i < CAP_COUNT; i++) begin : g_cap
        localparam int         HDR_DW = (CAP_BASE + CAP_STRIDE * i) / 4;
        localparam logic [7:0] NEXT   = (i == CAP_COUNT - 1) ? 8'h00
                                        : 8'(CAP_BASE + CAP_STRIDE * (i + 1));
        assign hit_v[i]          = (dw == DW_BITS'(HDR_DW));
        assign hdr_v[32*i +: 32] = {16'h0000, NEXT, CAP_IDS[8*i +: 8]};
    end

    always_comb begin
        hit  = |hit_v;
        data = '0;
        for (int i = 0; i < CAP_COUNT; i++) begin
            if (hit_v[i]) data = hdr_v[32*i +: 32];
        end
    end

endmodule

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
    import cfgsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output cmd_t        cmd
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (wr && be[0]) begin
            cmd.io_en  <= wdata[0];
            cmd.mem_en <= wdata[1];
            cmd.bm_en  <= wdata[2];
        end
    end

endmodule

// File: rtl/cfg_endpoint_regs.sv
module cfg_endpoint_regs
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB2,
    parameter logic [15:0] DEVICE_ID = 16'h0C41,
    parameter logic [6*NUM_BARS-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd8, 6'd5, 6'd12, 6'd4},
    parameter logic [NUM_BARS-1:0]   BAR_IO   = 6'b000100,
    parameter logic [NUM_BARS-1:0]   BAR_PREF = 6'b000010,
    parameter int CAP_COUNT  = 2,
    parameter int CAP_BASE   = 'h40,
    parameter int CAP_STRIDE = 16,
    parameter logic [8*CAP_COUNT-1:0] CAP_IDS = {8'h05, 8'h01}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_req,
    input  logic         cfg_we,
    input  logic [9:0]   cfg_dw,
    input  logic [3:0]   cfg_be,
    input  logic [31:0]  cfg_wdata,
    output logic         cfg_rvalid,
    output logic [31:0]  cfg_rdata,
    output logic         io_space_en,
    output logic         mem_space_en,
    output logic         bus_master_en
);

    logic                   wr_en;
    logic                   rd_en;
    logic [NUM_BARS-1:0]    bar_wr_sel;
    logic [32*NUM_BARS-1:0] bar_rd;
    logic                   cap_hit;
    logic [31:0]            cap_data;
    logic [31:0]            rd_next;
    cmd_t                   cmd;

    assign wr_en = cfg_req &&  cfg_we;
    assign rd_en = cfg_req && !cfg_we;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_sel
        assign bar_wr_sel[i] = wr_en && (cfg_dw == DW_BITS'(BAR_FIRST_DW + i));
    end

    cfg_cmd_reg u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && (cfg_dw == DW_BITS'(CMD_DW))),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .cmd   (cmd)
    );

    cfg_bar_bank #(
        .BAR_LOG2 (BAR_LOG2),
        .BAR_IO   (BAR_IO),
        .BAR_PREF (BAR_PREF)
    ) u_bars (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (bar_wr_sel),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .bar_rd (bar_rd)
    );

    cfg_cap_chain #(
        .CAP_COUNT  (CAP_COUNT),
        .CAP_BASE   (CAP_BASE),
        .CAP_STRIDE (CAP_STRIDE),
        .CAP_IDS    (CAP_IDS)
    ) u_caps (
        .dw   (cfg_dw),
        .hit  (cap_hit),
        .data (cap_data)
    );

    always_comb begin
        rd_next = '0;
        if (cfg_dw == DW_BITS'(ID_DW)) begin
            rd_next = {DEVICE_ID, VENDOR_ID};
        end else if (cfg_dw == DW_BITS'(CMD_DW)) begin
            rd_next = {11'h000, 1'b1, 4'h0, 13'h0000, cmd.bm_en, cmd.mem_en, cmd.io_en};
        end else if (cfg_dw == DW_BITS'(CAPPTR_DW)) begin
            rd_next = {24'h0, 8'(CAP_BASE)};
        end else if (cap_hit) begin
            rd_next = cap_data;
        end else begin
            for (int i = 0; i < NUM_BARS; i++) begin
                if (cfg_dw == DW_BITS'(BAR_FIRST_DW + i)) rd_next = bar_rd[32*i +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= rd_en;
            cfg_rdata  <= rd_en ? rd_next : 32'h0;
        end
    end

    assign io_space_en   = cmd.io_en;
    assign mem_space_en  = cmd.mem_en;
    assign bus_master_en = cmd.bm_en;

endmodule

// File: rtl/cfg_endpoint_regs_chk.sv
module cfg_endpoint_regs_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h1AB2,
    parameter logic [15:0] DEVICE_ID = 16'h0C41
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic [9:0]  cfg_dw,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_rvalid_data,
    input logic        cfg_rvalid,
    input logic        io_space_en,
    input logic        mem_space_en,
    input logic        bus_master_en
);

    // R11: valid follows a read request by one cycle
    a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we) |=> cfg_rvalid);

    // R11: no valid without a read request
    a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && !cfg_we) |=> !cfg_rvalid);

    // R2: identity dword always answers with the fixed codes
    a_r2_identity_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && cfg_dw == 10'd0) |=> (cfg_rvalid_data == {DEVICE_ID, VENDOR_ID}));

    // R4: status word shows only the capability list flag; command upper bits zero (R3)
    a_r4_status_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && cfg_dw == 10'd1) |=>
        (cfg_rvalid_data[31:21] == 11'h0 && cfg_rvalid_data[20] && cfg_rvalid_data[19:3] == 17'h0));

    // R3: enables move only on a lane-0 write to the command dword
    a_r3_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && cfg_we && cfg_dw == 10'd1 && cfg_be[0]) |=>
        $stable({io_space_en, mem_space_en, bus_master_en}));

    // R10: an unimplemented dword reads zero
    a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && cfg_dw == 10'd2) |=> (cfg_rvalid_data == 32'h0));

endmodule

bind cfg_endpoint_regs cfg_endpoint_regs_chk #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_req         (cfg_req),
    .cfg_we          (cfg_we),
    .cfg_dw          (cfg_dw),
    .cfg_be          (cfg_be),
    .cfg_rvalid_data (cfg_rdata),
    .cfg_rvalid      (cfg_rvalid),
    .io_space_en     (io_space_en),
    .mem_space_en    (mem_space_en),
    .bus_master_en   (bus_master_en)
);

// File: tb/cfg_endpoint_regs_bench.sv
module cfg_endpoint_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VEN = 16'h1AB2;
    localparam logic [15:0] DEV = 16'h0C41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        io_space_en, mem_space_en, bus_master_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic        last_rvalid;

    cfg_endpoint_regs u_cfg_endpoint_regs (
        .clk (clk), .rst_n (rst_n), .cfg_req (cfg_req), .cfg_we (cfg_we),
        .cfg_dw (cfg_dw), .cfg_be (cfg_be), .cfg_wdata (cfg_wdata),
        .cfg_rvalid (cfg_rvalid), .cfg_rdata (cfg_rdata),
        .io_space_en (io_space_en), .mem_space_en (mem_space_en),
        .bus_master_en (bus_master_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [9:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
        last_rvalid = cfg_rvalid;
    endtask

    task automatic cfg_read(input logic [9:0] dw, output logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_dw = dw;
        @(negedge clk);
        cfg_req = 1'b0;
        d = cfg_rdata;
        last_rvalid = cfg_rvalid;
    endtask

    task automatic expect_rd(input string tag, input logic [9:0] dw, input logic [31:0] exp);
        logic [31:0] d;
        cfg_read(dw, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset();
        check("R1 enables after reset", {29'h0, bus_master_en, mem_space_en, io_space_en}, 32'h0);
        expect_rd("R1 command after reset", 10'd1, 32'h0010_0000);
        expect_rd("R1 bar0 reset", 10'd4, 32'h0000_0000);
        expect_rd("R1 bar1 reset", 10'd5, 32'h0000_0008);
        expect_rd("R1 bar2 reset", 10'd6, 32'h0000_0001);
        expect_rd("R1 bar3 reset", 10'd7, 32'h0000_0000);
    endtask

    task automatic t_identity();
        expect_rd("R2 identity", 10'd0, {DEV, VEN});
        cfg_write(10'd0, 4'hF, 32'hFFFF_FFFF);
        expect_rd("R2 identity after write", 10'd0, {DEV, VEN});
    endtask

    task automatic t_command();
        cfg_write(10'd1, 4'hF, 32'hFFFF_FFFF);
        expect_rd("R3 command all ones", 10'd1, 32'h0010_0007);
        check("R3 enable pins", {29'h0, bus_master_en, mem_space_en, io_space_en}, 32'h7);
        cfg_write(10'd1, 4'b1110, 32'h0000_0000);
        expect_rd("R8 command upper lanes only", 10'd1, 32'h0010_0007);
        cfg_write(10'd1, 4'b0001, 32'h0000_0002);
        expect_rd("R3 memory only", 10'd1, 32'h0010_0002);
        check("R3 pins memory only", {29'h0, bus_master_en, mem_space_en, io_space_en}, 32'h2);
    endtask

    task automatic t_status();
        cfg_write(10'd1, 4'b1100, 32'h0000_0000);
        expect_rd("R4 status after zero write", 10'd1, 32'h0010_0002);
        cfg_write(10'd1, 4'b1100, 32'hFFFF_0002);
        expect_rd("R4 status after ones write", 10'd1, 32'h0010_0002);
    endtask

    task automatic t_probe();
        for (int i = 4; i <= 9; i++) cfg_write(10'(i), 4'hF, 32'hFFFF_FFFF);
        expect_rd("R5 bar0 mask", 10'd4, 32'hFFFF_FFF0);
        expect_rd("R5 bar1 mask", 10'd5, 32'hFFFF_F008);
        expect_rd("R5 bar2 mask", 10'd6, 32'hFFFF_FFE1);
        expect_rd("R5 bar3 mask", 10'd7, 32'hFFFF_FF00);
        expect_rd("R7 bar4 absent", 10'd8, 32'h0);
        expect_rd("R7 bar5 absent", 10'd9, 32'h0);
    endtask

    task automatic t_base();
        for (int i = 4; i <= 7; i++) cfg_write(10'(i), 4'hF, 32'h1234_5678);
        expect_rd("R6 bar0 base", 10'd4, 32'h1234_5670);
        expect_rd("R6 bar1 base", 10'd5, 32'h1234_5008);
        expect_rd("R6 bar2 base", 10'd6, 32'h1234_5661);
        expect_rd("R6 bar3 base", 10'd7, 32'h1234_5600);
    endtask

    task automatic t_bytes();
        cfg_write(10'd7, 4'b0100, 32'h00AB_0000);
        expect_rd("R8 bar3 lane2", 10'd7, 32'h12AB_5600);
        cfg_write(10'd7, 4'b1000, 32'hCDEE_EEEE);
        expect_rd("R8 bar3 lane3", 10'd7, 32'hCDAB_5600);
        cfg_write(10'd4, 4'b0001, 32'h0000_00FF);
        expect_rd("R8 bar0 lane0", 10'd4, 32'h1234_56F0);
    endtask

    task automatic t_caps();
        logic [31:0] ptr, hdr;
        cfg_read(10'd13, ptr);
        check("R9 capability pointer", ptr, 32'h0000_0040);
        cfg_read(10'(ptr[7:2]), hdr);
        check("R9 first capability", hdr, 32'h0000_5001);
        cfg_read(10'(hdr[15:10]), hdr);
        check("R9 second capability", hdr, 32'h0000_0005);
    endtask

    task automatic t_unimpl();
        cfg_write(10'd2, 4'hF, 32'hDEAD_BEEF);
        expect_rd("R10 dword2", 10'd2, 32'h0);
        cfg_write(10'h15, 4'hF, 32'hDEAD_BEEF);
        expect_rd("R10 inside capability", 10'h15, 32'h0);
        expect_rd("R10 end of legacy", 10'h3F, 32'h0);
        cfg_write(10'h3FF, 4'hF, 32'hDEAD_BEEF);
        expect_rd("R10 end of extended", 10'h3FF, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        cfg_read(10'd0, d);
        check("R11 rvalid after read", {31'h0, last_rvalid}, 32'h1);
        @(negedge clk);
        check("R11 rvalid drops", {31'h0, cfg_rvalid}, 32'h0);
        cfg_write(10'd4, 4'hF, 32'h0);
        check("R11 no rvalid on write", {31'h0, last_rvalid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_command();
        t_status();
        t_probe();
        t_base();
        t_bytes();
        t_caps();
        t_unimpl();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule